// File: doc/BRIEF.md
# Asymmetric Decode Slot Allocator

This block sits between two per-thread queues of pre-decoded instructions and a row of four decode slots. Each queue shows its oldest four entries to the block. Every entry carries a valid bit, a 3-bit count of the fused micro-ops it expands to, and a flag that marks it as a macro-fused pair. Each cycle the block picks one thread and moves a program-ordered prefix of that thread's window into the slots. It reports at once how many entries the thread gave up, so that the queue can pop them before the thread's next turn.

Slot 0 is the only slot that can handle an instruction needing two to four micro-ops. Slots 1 to 3 take only single-micro-op instructions. Every micro-op beyond the first one in slot 0 removes one simple slot from that cycle, so a cycle never issues more than four micro-ops. One macro-fused pair per cycle may occupy a slot, which lets five instructions through in one cycle. Thread service alternates cycle by cycle, and a thread with nothing to offer gives its turn away.

Top module: `dec_slot_alloc`

## Requirements
- R1: After a synchronous reset, `slot_vld`, `slot_uops`, `insn_cnt` and `dec_err` are all zero, and the first served cycle favours thread 0.
- R2: Slots 1 to 3 only ever receive an entry whose micro-op count is 1. An entry needing more than one micro-op that is not at window position 0 stops allocation for the cycle and is not consumed.
- R3: Slot 0 accepts counts 1 to 4. With a count of c in slot 0, at most 4 - c simple slots are valid (so the slot-valid population is at most 5 - c).
- R4: The micro-op counts of the valid slots never add up to more than 4.
- R5: Entries are taken as a contiguous prefix of the window in program order. Window entry i goes to slot i, and an invalid entry ends the prefix. `slot_vld` bit s is slot s. Slot s's count sits in `slot_uops[3*s+2:3*s]` and is zero when the slot is invalid.
- R6: A toggle picks the favoured thread (0 or 1), and a thread is ready when its window entry 0 is valid. The favoured thread is served if it is ready, otherwise the other one. Only the served thread's consume count is non-zero. `srv_thr` reports the served thread (0 or 1).
- R7: At most one macro-fused entry is taken per cycle; a second one stops allocation before it. `insn_cnt` equals the entries taken plus one if a fused entry was among them, so it reaches 5.
- R8: While `stall` is high both consume counts are zero, the next cycle's slot outputs are invalid, and the toggle does not advance.
- R9: An entry reached in program order whose count is 0 or above 4 is not consumed, ends allocation, and raises `dec_err` on the next cycle.
- R10: `cons_t0`/`cons_t1` respond in the same cycle as the window. `slot_vld`, `slot_uops`, `insn_cnt`, `srv_thr` and `dec_err` are registered and describe the previous cycle's pick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Downstream hold; nothing is issued or consumed |
| t0_vld | input | 4 | Thread 0 window entry valid bits, bit i is entry i |
| t0_uops | input | 12 | Thread 0 micro-op counts, entry i at [3i+2:3i] |
| t0_fused | input | 4 | Thread 0 macro-fused flags |
| t1_vld | input | 4 | Thread 1 window entry valid bits |
| t1_uops | input | 12 | Thread 1 micro-op counts |
| t1_fused | input | 4 | Thread 1 macro-fused flags |
| cons_t0 | output | 3 | Entries consumed from thread 0 this cycle |
| cons_t1 | output | 3 | Entries consumed from thread 1 this cycle |
| slot_vld | output | 4 | Registered per-slot valid |
| slot_uops | output | 12 | Registered per-slot micro-op count |
| insn_cnt | output | 3 | Registered instruction count issued |
| srv_thr | output | 1 | Registered thread that was served |
| dec_err | output | 1 | Registered illegal-count flag |

## Verification
The properties assume that the queues present a window that stays stable between consume updates, and that micro-op counts only appear on entries marked valid. The cycle-to-cycle link between consume counts and slot valids also relies on nothing but `stall` and the windows deciding a pick. The directed stimulus changes window contents only between clock edges and clears every window after each scenario. Illegal counts are placed only where the program-order scan reaches them, so that both the reported error and the untouched entries behind it are observable.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  typedef enum logic {THR0 = 1'b0, THR1 = 1'b1} thr_e;

  function automatic thr_e other_thr(input thr_e t);
    return (t == THR0) ? THR1 : THR0;
  endfunction
endpackage

// File: rtl/dsa_turn.sv
module dsa_turn
  import dsa_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stall,
  input  logic rdy0,
  input  logic rdy1,
  output thr_e sel,
  output logic act
);
  thr_e turn_q;
  logic fav_rdy;

  always_ff @(posedge clk) begin
    if (rst)
      turn_q <= THR0;
    else if (!stall)
      turn_q <= other_thr(turn_q);
  end

  always_comb begin
    fav_rdy = (turn_q == THR0) ? rdy0 : rdy1;
    sel     = fav_rdy ? turn_q : other_thr(turn_q);
    act     = rdy0 | rdy1;
  end
endmodule

// File: rtl/dsa_pick.sv
module dsa_pick #(
  parameter int NSLOT = 4,
  parameter int CW    = 3,
  parameter int MAXU  = 4,
  parameter int NW    = 3,
  parameter int IW    = 3
) (
  input  logic                  en,
  input  logic [NSLOT-1:0]      vld,
  input  logic [NSLOT*CW-1:0]   uops,
  input  logic [NSLOT-1:0]      fused,
  output logic [NSLOT-1:0]      take,
  output logic [NW-1:0]         n_take,
  output logic [IW-1:0]         n_insn,
  output logic                  err
);
  localparam int AW = CW + $clog2(NSLOT + 1) + 1;

  logic [NSLOT-1:0] go;
  logic [NSLOT-1:0] fz;
  logic [NSLOT-1:0] bad;
  logic [CW-1:0]    u0;

  assign u0    = uops[CW-1:0];
  assign go[0] = en;
  assign fz[0] = 1'b0;

  for (genvar i = 0; i < NSLOT; i++) begin : g_ent
    logic [CW-1:0] u;
    logic          legal;
    logic          fit;
    logic          fok;

    assign u     = uops[i*CW +: CW];
    assign legal = (u != '0) && (AW'(u) <= AW'(MAXU));
    assign fok   = !(fused[i] && fz[i]);

    if (i == 0) begin : g_cx
      assign fit = 1'b1;
    end else begin : g_sp
      assign fit = (u == CW'(1)) && ((AW'(i) + AW'(u0)) <= AW'(NSLOT));
    end

    assign take[i] = go[i] && vld[i] && legal && fit && fok;
    assign bad[i]  = go[i] && vld[i] && !legal;

    if (i < NSLOT - 1) begin : g_nx
      assign go[i+1] = take[i];
      assign fz[i+1] = fz[i] | (take[i] & fused[i]);
    end
  end

  always_comb begin
    n_take = '0;
    n_insn = '0;
    for (int i = 0; i < NSLOT; i++) begin
      n_take = n_take + NW'(take[i]);
      n_insn = n_insn + IW'(take[i]) + IW'(take[i] & fused[i]);
    end
    err = |bad;
  end
endmodule

// File: rtl/dsa_outreg.sv
module dsa_outreg
  import dsa_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int CW    = 3,
  parameter int IW    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                upd,
  input  thr_e                sel,
  input  logic [NSLOT-1:0]    take,
  input  logic [NSLOT*CW-1:0] uops,
  input  logic [IW-1:0]       n_insn,
  input  logic                err,
  output logic [NSLOT-1:0]    slot_vld,
  output logic [NSLOT*CW-1:0] slot_uops,
  output logic [IW-1:0]       insn_cnt,
  output logic                srv_thr,
  output logic                dec_err
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || !upd || !take[s]) begin
        slot_vld[s]              <= 1'b0;
        slot_uops[s*CW +: CW]    <= '0;
      end else begin
        slot_vld[s]              <= 1'b1;
        slot_uops[s*CW +: CW]    <= uops[s*CW +: CW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      insn_cnt <= '0;
      dec_err  <= 1'b0;
      srv_thr  <= 1'b0;
    end else begin
      insn_cnt <= upd ? n_insn : '0;
      dec_err  <= upd & err;
      if (upd)
        srv_thr <= (sel == THR1);
    end
  end
endmodule

// File: rtl/dec_slot_alloc.sv
module dec_slot_alloc
  import dsa_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int CW    = 3,
  parameter int MAXU  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stall,
  input  logic [NSLOT-1:0]     t0_vld,
  input  logic [NSLOT*CW-1:0]  t0_uops,
  input  logic [NSLOT-1:0]     t0_fused,
  input  logic [NSLOT-1:0]     t1_vld,
  input  logic [NSLOT*CW-1:0]  t1_uops,
  input  logic [NSLOT-1:0]     t1_fused,
  output logic [$clog2(NSLOT+1)-1:0] cons_t0,
  output logic [$clog2(NSLOT+1)-1:0] cons_t1,
  output logic [NSLOT-1:0]     slot_vld,
  output logic [NSLOT*CW-1:0]  slot_uops,
  output logic [$clog2(NSLOT+2)-1:0] insn_cnt,
  output logic                 srv_thr,
  output logic                 dec_err
);
  localparam int NW = $clog2(NSLOT + 1);
  localparam int IW = $clog2(NSLOT + 2);

  thr_e                sel;
  logic                act;
  logic                en;
  logic [NSLOT-1:0]    w_vld;
  logic [NSLOT*CW-1:0] w_uops;
  logic [NSLOT-1:0]    w_fused;
  logic [NSLOT-1:0]    take;
  logic [NW-1:0]       n_take;
  logic [IW-1:0]       n_insn;
  logic                err;

  dsa_turn u_turn (
    .clk   (clk),
    .rst   (rst),
    .stall (stall),
    .rdy0  (t0_vld[0]),
    .rdy1  (t1_vld[0]),
    .sel   (sel),
    .act   (act)
  );

  assign en      = act & ~stall & ~rst;
  assign w_vld   = (sel == THR1) ? t1_vld   : t0_vld;
  assign w_uops  = (sel == THR1) ? t1_uops  : t0_uops;
  assign w_fused = (sel == THR1) ? t1_fused : t0_fused;

  dsa_pick #(.NSLOT(NSLOT), .CW(CW), .MAXU(MAXU), .NW(NW), .IW(IW)) u_pick (
    .en     (en),
    .vld    (w_vld),
    .uops   (w_uops),
    .fused  (w_fused),
    .take   (take),
    .n_take (n_take),
    .n_insn (n_insn),
    .err    (err)
  );

  assign cons_t0 = (sel == THR0) ? n_take : '0;
  assign cons_t1 = (sel == THR1) ? n_take : '0;

  dsa_outreg #(.NSLOT(NSLOT), .CW(CW), .IW(IW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .upd       (en),
    .sel       (sel),
    .take      (take),
    .uops      (w_uops),
    .n_insn    (n_insn),
    .err       (err),
    .slot_vld  (slot_vld),
    .slot_uops (slot_uops),
    .insn_cnt  (insn_cnt),
    .srv_thr   (srv_thr),
    .dec_err   (dec_err)
  );
endmodule

// File: rtl/dsa_checker.sv
module dsa_checker #(
  parameter int NSLOT = 4,
  parameter int CW    = 3,
  parameter int MAXU  = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         stall,
  input logic [$clog2(NSLOT+1)-1:0]   cons_t0,
  input logic [$clog2(NSLOT+1)-1:0]   cons_t1,
  input logic [NSLOT-1:0]             slot_vld,
  input logic [NSLOT*CW-1:0]          slot_uops,
  input logic [$clog2(NSLOT+2)-1:0]   insn_cnt
);
  localparam int SW = CW + $clog2(NSLOT + 1) + 1;

  logic [SW-1:0] usum;
  logic          seen;

  always_comb begin
    usum = '0;
    for (int s = 0; s < NSLOT; s++)
      if (slot_vld[s]) usum = usum + SW'(slot_uops[s*CW +: CW]);
  end

  always_ff @(posedge clk) seen <= !rst;

  for (genvar s = 1; s < NSLOT; s++) begin : g_chk
    // R2: simple slots carry single micro-op entries only
    a_r2_simple_one: assert property (@(posedge clk) disable iff (rst)
      slot_vld[s] |-> (slot_uops[s*CW +: CW] == CW'(1)));
    // R5: valid slots form a prefix
    a_r5_prefix: assert property (@(posedge clk) disable iff (rst)
      slot_vld[s] |-> slot_vld[s-1]);
  end

  a_r3_simple_cut: assert property (@(posedge clk) disable iff (rst)
    slot_vld[0] |-> ($countones(slot_vld) + int'(slot_uops[CW-1:0]) <= NSLOT + 1));

  a_r4_uop_total: assert property (@(posedge clk) disable iff (rst)
    usum <= SW'(MAXU));

  a_r6_one_thread: assert property (@(posedge clk) disable iff (rst)
    !((cons_t0 != '0) && (cons_t1 != '0)));

  a_r7_insn_bound: assert property (@(posedge clk) disable iff (rst)
    (int'(insn_cnt) >= $countones(slot_vld)) && (int'(insn_cnt) <= $countones(slot_vld) + 1));

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> (slot_vld == '0));

  a_r8_stall_nocons: assert property (@(posedge clk) disable iff (rst)
    stall |-> ((cons_t0 == '0) && (cons_t1 == '0)));

  a_r10_cons_match: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(stall)) |->
      ($countones(slot_vld) == int'($past(cons_t0)) + int'($past(cons_t1))));
endmodule

bind dec_slot_alloc dsa_checker #(.NSLOT(NSLOT), .CW(CW), .MAXU(MAXU)) u_chk (.*);

// File: tb/dec_slot_alloc_bench.sv
module dec_slot_alloc_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [3:0]  t0_vld = '0, t1_vld = '0, t0_fused = '0, t1_fused = '0;
  logic [11:0] t0_uops = '0, t1_uops = '0;
  logic [2:0]  cons_t0, cons_t1, insn_cnt;
  logic [3:0]  slot_vld;
  logic [11:0] slot_uops;
  logic        srv_thr, dec_err;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  exp_turn = 1'b0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_slot_alloc u_dec_slot_alloc (.*);

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    if (!stall) exp_turn = ~exp_turn;
  endtask

  task automatic clear();
    t0_vld = '0; t1_vld = '0; t0_fused = '0; t1_fused = '0;
    t0_uops = '0; t1_uops = '0; stall = 1'b0;
  endtask

  // one cycle on thread 0 alone; thread 1 idle
  task automatic run_t0(input string tag, input logic [3:0] v, input logic [11:0] u,
                        input logic [3:0] f, input int e_cons, input logic [3:0] e_vld,
                        input logic [11:0] e_uops, input int e_insn, input int e_err);
    t0_vld = v; t0_uops = u; t0_fused = f;
    #1;
    check(tag, "cons_t0", int'(cons_t0), e_cons);
    check(tag, "cons_t1", int'(cons_t1), 0);
    step();
    check(tag, "slot_vld", int'(slot_vld), int'(e_vld));
    check(tag, "slot_uops", int'(slot_uops), int'(e_uops));
    check(tag, "insn_cnt", int'(insn_cnt), e_insn);
    check(tag, "dec_err", int'(dec_err), e_err);
    check(tag, "srv_thr", int'(srv_thr), 0);
    clear();
  endtask

  task automatic t_reset();
    check("R1", "slot_vld", int'(slot_vld), 0);
    check("R1", "slot_uops", int'(slot_uops), 0);
    check("R1", "insn_cnt", int'(insn_cnt), 0);
    check("R1", "dec_err", int'(dec_err), 0);
    // first served cycle with both ready goes to thread 0
    t0_vld = 4'b0001; t0_uops = 12'o0001; t1_vld = 4'b0001; t1_uops = 12'o0001;
    #1;
    check("R1", "cons_t0 first", int'(cons_t0), 1);
    check("R1", "cons_t1 first", int'(cons_t1), 0);
    step();
    check("R1", "srv_thr first", int'(srv_thr), 0);
    clear();
  endtask

  task automatic t_simple();
    run_t0("R5", 4'b1111, 12'o1111, 4'b0000, 4, 4'b1111, 12'o1111, 4, 0);
    run_t0("R10", 4'b0011, 12'o0011, 4'b0000, 2, 4'b0011, 12'o0011, 2, 0);
  endtask

  task automatic t_complex();
    run_t0("R3", 4'b1111, 12'o1112, 4'b0000, 3, 4'b0111, 12'o0112, 3, 0);
    run_t0("R3", 4'b1111, 12'o1113, 4'b0000, 2, 4'b0011, 12'o0013, 2, 0);
    run_t0("R4", 4'b1111, 12'o1114, 4'b0000, 1, 4'b0001, 12'o0004, 1, 0);
  endtask

  task automatic t_order();
    run_t0("R2", 4'b1111, 12'o1121, 4'b0000, 1, 4'b0001, 12'o0001, 1, 0);
    run_t0("R2", 4'b1111, 12'o2111, 4'b0000, 3, 4'b0111, 12'o0111, 3, 0);
    run_t0("R5", 4'b1011, 12'o1111, 4'b0000, 2, 4'b0011, 12'o0011, 2, 0);
  endtask

  task automatic t_fused();
    run_t0("R7", 4'b1111, 12'o1111, 4'b0001, 4, 4'b1111, 12'o1111, 5, 0);
    run_t0("R7", 4'b1111, 12'o1111, 4'b0101, 2, 4'b0011, 12'o0011, 3, 0);
  endtask

  task automatic t_err();
    run_t0("R9", 4'b1111, 12'o1011, 4'b0000, 2, 4'b0011, 12'o0011, 2, 1);
    run_t0("R9", 4'b1111, 12'o1115, 4'b0000, 0, 4'b0000, 12'o0000, 0, 1);
  endtask

  task automatic t_alt();
    for (int k = 0; k < 3; k++) begin
      bit fav;
      fav = exp_turn;
      t0_vld = 4'b1111; t0_uops = 12'o1111; t1_vld = 4'b1111; t1_uops = 12'o1111;
      #1;
      check("R6", "cons_t0 alt", int'(cons_t0), fav ? 0 : 4);
      check("R6", "cons_t1 alt", int'(cons_t1), fav ? 4 : 0);
      step();
      check("R6", "srv_thr alt", int'(srv_thr), int'(fav));
    end
    clear();
    // favoured thread idle: the other takes the turn
    begin
      bit fav;
      fav = exp_turn;
      if (fav) begin t0_vld = 4'b0011; t0_uops = 12'o0011; end
      else     begin t1_vld = 4'b0011; t1_uops = 12'o0011; end
      #1;
      check("R6", "cons_t0 idle", int'(cons_t0), fav ? 2 : 0);
      check("R6", "cons_t1 idle", int'(cons_t1), fav ? 0 : 2);
      step();
      check("R6", "srv_thr idle", int'(srv_thr), fav ? 0 : 1);
    end
    clear();
  endtask

  task automatic t_stall();
    bit fav;
    fav = exp_turn;
    t0_vld = 4'b1111; t0_uops = 12'o1111; t1_vld = 4'b1111; t1_uops = 12'o1111;
    stall = 1'b1;
    #1;
    check("R8", "cons_t0 stall", int'(cons_t0), 0);
    check("R8", "cons_t1 stall", int'(cons_t1), 0);
    step();
    check("R8", "slot_vld stall", int'(slot_vld), 0);
    check("R8", "insn_cnt stall", int'(insn_cnt), 0);
    stall = 1'b0;
    #1;
    check("R8", "cons_t0 after", int'(cons_t0), fav ? 0 : 4);
    check("R8", "cons_t1 after", int'(cons_t1), fav ? 4 : 0);
    step();
    check("R8", "srv_thr after", int'(srv_thr), int'(fav));
    clear();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    exp_turn = 1'b0;
    t_reset();
    t_simple();
    t_complex();
    t_order();
    t_fused();
    t_err();
    t_alt();
    t_stall();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule